// File: doc/BRIEF.md
# Bus Handoff Controller

This block sits beside a processor core and lets an outside master take over the core's external memory bus. The outside master raises a request. The controller then waits until the memory access in flight has finished, not the whole instruction. After that it floats the address, data and strobe drivers, raises a grant and stops the core. When the request falls, the grant drops, the drivers come back in the same edge, and the core resumes from the point where it stopped.

The request is asynchronous, so it passes through a configurable synchronizer chain before it is used. The core is modelled only by three status inputs: an access in flight, a strobe marking the last cycle of an access, and a flag saying that the next instruction wants external memory. A run-on mode lets the core keep executing while it does not own the bus, and stalls it only when it wants the bus.

The handoff logic has its own power-on reset. The core reset does not stop it: a request is served while the core is held in reset, and during that time the in-flight flag is treated as an aborted access.

Top module: `bus_handoff_ctrl`

## Requirements
- R1: While `por_n_i` is low, and on the first edge after it rises, `bus_grant_o`=0, `drv_en_o`=1, `core_halt_o`=0 and `grant_hung_o`=0.
- R2: With no access in flight and `SYNC_STAGES`=2, `bus_grant_o` rises on the third rising edge after `bus_req_i` is first sampled high, and stays low on the second.
- R3: While `ext_busy_i`=1 and `acc_done_i`=0, no grant is issued. The grant rises on the edge that samples `acc_done_i`=1 together with a synchronized request.
- R4: When `acc_done_i` of one access and the synchronized request fall in the same cycle, the grant is issued at that edge, before the next access of the same instruction starts.
- R5: `drv_en_o` is always the inverse of `bus_grant_o`, and both change on the same edge.
- R6: With `go_mode_i`=0, `core_halt_o` equals `bus_grant_o`.
- R7: After `bus_req_i` falls, the grant stays high for two more edges and drops on the third.
- R8: With `go_mode_i`=1 and the grant held, `core_halt_o` equals `need_ext_i`. Without the grant, `core_halt_o` is 0.
- R9: `grant_hung_o` is 1 exactly when `core_halt_o`=1 and `core_rst_i`=0.
- R10: While `core_rst_i`=1, requests are still granted with the same latency, and `ext_busy_i` is treated as no access in flight.
- R11: If the synchronized request falls while the grant is still waiting on an access, the pending grant is cancelled, and a later `acc_done_i` raises no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| por_n_i | input | 1 | Power-on reset of the handoff logic, active low, asynchronous |
| core_rst_i | input | 1 | Core reset, active high |
| bus_req_i | input | 1 | Bus request from the outside master, asynchronous |
| go_mode_i | input | 1 | Run-on mode: the core keeps executing while the bus is granted |
| ext_busy_i | input | 1 | An external access is in flight |
| acc_done_i | input | 1 | Last cycle of the current external access |
| need_ext_i | input | 1 | The next instruction needs external memory |
| bus_grant_o | output | 1 | Bus granted to the outside master (registered) |
| drv_en_o | output | 1 | Output enable for the address, data and strobe drivers (registered) |
| core_halt_o | output | 1 | Stalls the core |
| grant_hung_o | output | 1 | The core is ready to run but is stalled by the grant |

## Verification
Two things can meet in one cycle: the completion strobe of an access, and the synchronized request becoming valid. The bench lines up `acc_done_i` with the edge where the request leaves the synchronizer. It expects the grant on exactly that edge, and expects it before the model core starts the instruction's second access. A second collision is the request being withdrawn while the grant still waits on an access. Here the completion strobe arrives after the synchronized request has already fallen, and the bench requires the grant to stay low through and after it.

// File: rtl/bho_pkg.sv
`timescale 1ns/1ps
package bho_pkg;

    typedef enum logic [1:0] {
        HO_IDLE  = 2'd0,
        HO_WAIT  = 2'd1,
        HO_OWNED = 2'd2
    } ho_state_e;

    typedef struct packed {
        ho_state_e st;
        logic      grant;
        logic      drv_en;
    } ho_regs_t;

    localparam ho_regs_t HO_RESET = '{st: HO_IDLE, grant: 1'b0, drv_en: 1'b1};

endpackage

// File: rtl/bho_sync.sv
`timescale 1ns/1ps
module bho_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            assign sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};

            // R2
            sync_shift_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
                $rose(sh_q[STAGES-1]) |-> $past(sh_q[STAGES-2]));
        end
    endgenerate

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) sh_q <= '0;
        else          sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/bho_fsm.sv
`timescale 1ns/1ps
module bho_fsm
    import bho_pkg::*;
(
    input  logic clk_i,
    input  logic por_n_i,
    input  logic req_s_i,
    input  logic busy_i,
    input  logic done_i,
    input  logic core_rst_i,
    output logic grant_o,
    output logic drv_en_o
);
    ho_regs_t r_d, r_q;
    logic     free;

    always_comb begin
        free = ~(busy_i & ~core_rst_i) | done_i;
        r_d  = r_q;
        unique case (r_q.st)
            HO_IDLE: begin
                if (req_s_i) r_d.st = free ? HO_OWNED : HO_WAIT;
            end
            HO_WAIT: begin
                if (!req_s_i)  r_d.st = HO_IDLE;
                else if (free) r_d.st = HO_OWNED;
            end
            HO_OWNED: begin
                if (!req_s_i) r_d.st = HO_IDLE;
            end
            default: r_d.st = HO_IDLE;
        endcase
        r_d.grant  = (r_d.st == HO_OWNED);
        r_d.drv_en = (r_d.st != HO_OWNED);
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) r_q <= HO_RESET;
        else          r_q <= r_d;
    end

    assign grant_o  = r_q.grant;
    assign drv_en_o = r_q.drv_en;

    // R3
    grant_after_free_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(grant_o) |-> ($past(free) && $past(req_s_i)));

    // R5
    drv_vs_grant_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        drv_en_o != grant_o);

    // R7
    release_next_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (grant_o && !req_s_i) |=> !grant_o);

    // R11
    no_grant_unrequested_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (!grant_o && !req_s_i) |=> !grant_o);
endmodule

// File: rtl/bho_halt.sv
`timescale 1ns/1ps
module bho_halt (
    input  logic grant_i,
    input  logic go_mode_i,
    input  logic need_ext_i,
    input  logic core_rst_i,
    output logic halt_o,
    output logic hung_o
);
    always_comb begin
        halt_o = grant_i & (~go_mode_i | need_ext_i);
        hung_o = halt_o & ~core_rst_i;
    end
endmodule

// File: rtl/bus_handoff_ctrl.sv
`timescale 1ns/1ps
module bus_handoff_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic por_n_i,
    input  logic core_rst_i,
    input  logic bus_req_i,
    input  logic go_mode_i,
    input  logic ext_busy_i,
    input  logic acc_done_i,
    input  logic need_ext_i,
    output logic bus_grant_o,
    output logic drv_en_o,
    output logic core_halt_o,
    output logic grant_hung_o
);
    logic req_s;

    bho_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .por_n_i (por_n_i),
        .d_i     (bus_req_i),
        .q_o     (req_s)
    );

    bho_fsm u_fsm (
        .clk_i      (clk_i),
        .por_n_i    (por_n_i),
        .req_s_i    (req_s),
        .busy_i     (ext_busy_i),
        .done_i     (acc_done_i),
        .core_rst_i (core_rst_i),
        .grant_o    (bus_grant_o),
        .drv_en_o   (drv_en_o)
    );

    bho_halt u_halt (
        .grant_i    (bus_grant_o),
        .go_mode_i  (go_mode_i),
        .need_ext_i (need_ext_i),
        .core_rst_i (core_rst_i),
        .halt_o     (core_halt_o),
        .hung_o     (grant_hung_o)
    );

    // R6
    halt_when_owned_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (bus_grant_o && !go_mode_i) |-> core_halt_o);

    // R8
    no_halt_unowned_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        !bus_grant_o |-> !core_halt_o);

    // R9
    hung_needs_halt_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
        grant_hung_o |-> (core_halt_o && !core_rst_i));
endmodule

// File: tb/bus_handoff_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_handoff_ctrl_tb_top;
    logic clk = 1'b0;
    logic por_n, core_rst, bus_req, go_mode, ext_busy, acc_done, need_ext;
    logic bus_grant, drv_en, core_halt, grant_hung;

    always #2.5 clk = ~clk;

    bus_handoff_ctrl #(.SYNC_STAGES(2)) dut_i (
        .clk_i        (clk),
        .por_n_i      (por_n),
        .core_rst_i   (core_rst),
        .bus_req_i    (bus_req),
        .go_mode_i    (go_mode),
        .ext_busy_i   (ext_busy),
        .acc_done_i   (acc_done),
        .need_ext_i   (need_ext),
        .bus_grant_o  (bus_grant),
        .drv_en_o     (drv_en),
        .core_halt_o  (core_halt),
        .grant_hung_o (grant_hung)
    );

    typedef struct {
        int       due;
        logic [3:0] exp;
        string    tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    // expected {grant, drv_en, halt, hung} after n more rising edges
    task automatic expect_in(input int n, input logic [3:0] e, input string tag);
        item_t it;
        it.due = cyc + n;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare shortly after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #1;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due == cyc) begin
                    logic [3:0] got;
                    got = {bus_grant, drv_en, core_halt, grant_hung};
                    n_cmp++;
                    if (got !== q[i].exp) begin
                        n_bad++;
                        $display("FAIL %s: grant/drv/halt/hung got %b expected %b (cycle %0d)",
                                 q[i].tag, got, q[i].exp, cyc);
                    end
                    q.delete(i);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all R): got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; core_rst = 1'b0; bus_req = 1'b0; go_mode = 1'b0;
        ext_busy = 1'b0; acc_done = 1'b0; need_ext = 1'b0;

        // R1 reset state
        tick(2);
        expect_in(1, 4'b0100, "R1 during por");
        tick(2);
        por_n = 1'b1;
        expect_in(1, 4'b0100, "R1 after por");
        tick(2);

        // R2 idle request, R5 and R6 on the grant
        bus_req = 1'b1;
        expect_in(2, 4'b0100, "R2 still syncing");
        expect_in(3, 4'b1011, "R2 R5 R6 grant idle");
        tick(4);

        // R7 release
        bus_req = 1'b0;
        expect_in(2, 4'b1011, "R7 hold");
        expect_in(3, 4'b0100, "R7 R5 drop");
        tick(5);

        // R3 deferral behind one access
        ext_busy = 1'b1;
        bus_req  = 1'b1;
        expect_in(3, 4'b0100, "R3 defer early");
        expect_in(5, 4'b0100, "R3 defer late");
        tick(5);
        acc_done = 1'b1;
        expect_in(1, 4'b1011, "R3 grant after done");
        tick(1);
        ext_busy = 1'b0;
        acc_done = 1'b0;
        tick(2);
        bus_req = 1'b0;
        tick(5);

        // R4 completion strobe meets synchronized request
        bus_req  = 1'b1;
        ext_busy = 1'b1;
        expect_in(2, 4'b0100, "R4 first access running");
        expect_in(3, 4'b1011, "R4 grant between accesses");
        tick(2);
        acc_done = 1'b1;
        tick(1);
        ext_busy = 1'b0;
        acc_done = 1'b0;
        expect_in(1, 4'b1011, "R4 held, second access stalled");
        tick(2);
        bus_req = 1'b0;
        expect_in(3, 4'b0100, "R4 release");
        tick(3);
        ext_busy = 1'b1;
        expect_in(1, 4'b0100, "R4 second access no grant");
        tick(1);
        acc_done = 1'b1;
        tick(1);
        ext_busy = 1'b0;
        acc_done = 1'b0;
        tick(2);

        // R11 cancel while waiting
        ext_busy = 1'b1;
        bus_req  = 1'b1;
        tick(3);
        bus_req = 1'b0;
        tick(3);
        acc_done = 1'b1;
        expect_in(1, 4'b0100, "R11 no grant at done");
        expect_in(2, 4'b0100, "R11 no grant after");
        tick(1);
        ext_busy = 1'b0;
        acc_done = 1'b0;
        tick(3);

        // R8 run-on mode, R9 hung indication
        go_mode  = 1'b1;
        need_ext = 1'b0;
        bus_req  = 1'b1;
        expect_in(3, 4'b1000, "R8 runs while granted");
        tick(4);
        need_ext = 1'b1;
        expect_in(1, 4'b1011, "R8 R9 stall on need");
        tick(1);
        need_ext = 1'b0;
        expect_in(1, 4'b1000, "R8 resumes");
        tick(1);
        bus_req = 1'b0;
        expect_in(3, 4'b0100, "R8 release");
        tick(4);
        go_mode = 1'b0;

        // R10 request served during core reset
        core_rst = 1'b1;
        ext_busy = 1'b1;
        bus_req  = 1'b1;
        expect_in(2, 4'b0100, "R10 syncing");
        expect_in(3, 4'b1010, "R10 R9 grant in reset");
        tick(4);
        bus_req = 1'b0;
        expect_in(3, 4'b0100, "R10 release");
        tick(4);
        core_rst = 1'b0;
        ext_busy = 1'b0;
        tick(3);

        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard (all R): got %0d pending expected 0", q.size());
        end
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule